// File: doc/BRIEF.md
# Timing Reference Operating-Mode Controller

This block is the mode tracker for a digital PLL timing generator that selects its reference on its own. It receives qualified, synchronous condition flags from the surrounding logic: at least one reference is usable, the loop reports frequency lock, the loop reports synchronization, a stored holdover history is usable, and a request to move to another active reference. From these flags it keeps one of four operating modes: free-running, acquiring, locked and holdover. It presents that mode both as a binary code and as a one-hot vector.

The block also emits two single-cycle strobes. The first marks every mode transition, so an interrupt or status block can latch it. The second marks an accepted change of the active reference. Reference loss always takes priority. The block enters holdover only when a history exists to hold over with, and a returning reference always passes through the acquiring mode before it can count as locked.

The reset input is asserted asynchronously. Its release is resynchronized inside the block, so the first mode decision happens a few clocks after `rst_n` rises.

Top module: `refmode_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first transition, the mode is free-running (code 0) and both strobes are low. Mode codes: 0 free-running, 1 acquiring, 2 locked, 3 holdover.
- R2: In free-running or holdover, a usable reference moves the mode to acquiring on the next clock, even if frequency lock is reported in the same cycle.
- R3: In acquiring, with a reference present and no switch request, frequency lock moves the mode to locked on the next clock.
- R4: In acquiring or locked, loss of every reference moves the mode to holdover if the history flag is set, and to free-running if it is not. Loss of reference outranks frequency lock and switch requests seen in the same cycle.
- R5: Free-running with no reference stays free-running, whatever the history flag says.
- R6: In holdover, if the history flag drops while no reference is present, the mode falls to free-running.
- R7: In locked, a switch request with a reference present returns the mode to acquiring. In acquiring, a switch request keeps the mode in acquiring even when lock is reported.
- R8: In locked, when frequency lock and synchronization are both deasserted, the mode returns to acquiring. Either flag alone keeps it locked.
- R9: `mode_chg_o` is high for exactly the one cycle in which a new mode first appears on `mode_o`, and is low at all other times.
- R10: `ref_chg_o` is high for one cycle, aligned with the resulting mode, only when a switch request is accepted in acquiring or locked with a reference present. In free-running and holdover the request is ignored.
- R11: `mode_oh_o` always has exactly the bit set whose index equals `mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_avail_i | input | 1 | At least one qualified reference is usable |
| freq_lock_i | input | 1 | Loop reports frequency lock |
| sync_i | input | 1 | Loop reports synchronization |
| hist_avail_i | input | 1 | A usable holdover history exists |
| ref_switch_i | input | 1 | Request to change the active reference |
| mode_o | output | 2 | Current mode code |
| mode_oh_o | output | 4 | Current mode, one-hot |
| mode_chg_o | output | 1 | One-cycle strobe on every mode transition |
| ref_chg_o | output | 1 | One-cycle strobe on an accepted reference switch |

## Verification
A wrong state register is visible directly on `mode_o` and `mode_oh_o` in the same cycle it occurs, because both outputs come from the state flops. A wrong transition therefore shows one clock after the input pattern that triggered it. A strobe that fires on the wrong edge, or fails to fire, shows up in that same cycle against the mode code. The priority cases need particular care: lock reported together with reference loss, and a switch request together with lock. A wrong priority there looks like a normal transition to the wrong mode, so these cases are driven on purpose.

// File: rtl/refmode_pkg.sv
package refmode_pkg;
  localparam int unsigned MODE_W    = 2;
  localparam int unsigned NUM_MODES = 1 << MODE_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_FREERUN  = 2'd0,
    MODE_ACQUIRE  = 2'd1,
    MODE_LOCKED   = 2'd2,
    MODE_HOLDOVER = 2'd3
  } mode_e;

  typedef struct packed {
    logic ref_ok;
    logic lock;
    logic sync;
    logic hist;
    logic sw_req;
  } cond_t;
endpackage

// File: rtl/refmode_rst_sync.sv
module refmode_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/refmode_next.sv
module refmode_next
  import refmode_pkg::*;
(
  input  mode_e cur_mode,
  input  cond_t cond,
  output mode_e nxt_mode,
  output logic  sw_accept
);
  always_comb begin
    nxt_mode  = cur_mode;
    sw_accept = 1'b0;
    if (!cond.ref_ok) begin
      // reference loss outranks every other condition
      unique case (cur_mode)
        MODE_ACQUIRE,
        MODE_LOCKED:   nxt_mode = cond.hist ? MODE_HOLDOVER : MODE_FREERUN;
        MODE_HOLDOVER: nxt_mode = cond.hist ? MODE_HOLDOVER : MODE_FREERUN;
        default:       nxt_mode = MODE_FREERUN;
      endcase
    end else begin
      unique case (cur_mode)
        MODE_FREERUN,
        MODE_HOLDOVER: nxt_mode = MODE_ACQUIRE;
        MODE_ACQUIRE: begin
          if (cond.sw_req) begin
            sw_accept = 1'b1;
          end else if (cond.lock) begin
            nxt_mode = MODE_LOCKED;
          end
        end
        MODE_LOCKED: begin
          if (cond.sw_req) begin
            sw_accept = 1'b1;
            nxt_mode  = MODE_ACQUIRE;
          end else if (!cond.lock && !cond.sync) begin
            nxt_mode = MODE_ACQUIRE;
          end
        end
        default: nxt_mode = MODE_FREERUN;
      endcase
    end
  end
endmodule

// File: rtl/refmode_strobe.sv
module refmode_strobe #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] pulse_o
);
  logic [N-1:0] pulse_q;

  for (genvar g = 0; g < N; g++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pulse_q[g] <= 1'b0;
      else if (en) pulse_q[g] <= set_i[g];
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/refmode_ctrl.sv
module refmode_ctrl
  import refmode_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_avail_i,
  input  logic                 freq_lock_i,
  input  logic                 sync_i,
  input  logic                 hist_avail_i,
  input  logic                 ref_switch_i,
  output logic [MODE_W-1:0]    mode_o,
  output logic [NUM_MODES-1:0] mode_oh_o,
  output logic                 mode_chg_o,
  output logic                 ref_chg_o
);
  localparam int unsigned NSTB = 2;

  logic        rst_n_int;
  logic        upd_en;
  cond_t       cond;
  mode_e       mode_q;
  mode_e       mode_d;
  logic        sw_acc;
  logic [NSTB-1:0] stb_set;
  logic [NSTB-1:0] stb_q;

  refmode_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign cond = '{ref_ok: ref_avail_i, lock: freq_lock_i, sync: sync_i,
                  hist: hist_avail_i, sw_req: ref_switch_i};

  refmode_next u_next (
    .cur_mode  (mode_q),
    .cond      (cond),
    .nxt_mode  (mode_d),
    .sw_accept (sw_acc)
  );

  assign upd_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  mode_q <= MODE_FREERUN;
    else if (upd_en) mode_q <= mode_d;
  end

  assign stb_set = {sw_acc, (mode_d != mode_q)};

  refmode_strobe #(.N(NSTB)) u_stb (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en      (upd_en),
    .set_i   (stb_set),
    .pulse_o (stb_q)
  );

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_oh
    assign mode_oh_o[m] = (mode_q == mode_e'(m));
  end

  assign mode_o     = mode_q;
  assign mode_chg_o = stb_q[0];
  assign ref_chg_o  = stb_q[1];
endmodule

// File: rtl/refmode_ctrl_chk.sv
module refmode_ctrl_chk
  import refmode_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ref_avail_i,
  input logic                 hist_avail_i,
  input logic [MODE_W-1:0]    mode_o,
  input logic [NUM_MODES-1:0] mode_oh_o,
  input logic                 mode_chg_o,
  input logic                 ref_chg_o
);
  // R11
  assert_onehot_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_oh_o == (NUM_MODES'(1) << mode_o));

  // R9
  assert_chg_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_o == (mode_o != $past(mode_o)));

  // R4
  assert_noref_fallback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_avail_i |=> (mode_o == MODE_HOLDOVER || mode_o == MODE_FREERUN));

  // R6
  assert_holdover_needs_hist_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hist_avail_i |=> (mode_o != MODE_HOLDOVER));

  // R10
  assert_refchg_in_acquire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_chg_o |-> (mode_o == MODE_ACQUIRE));

  // R2
  assert_return_via_acquire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_LOCKED) |-> ($past(mode_o) == MODE_LOCKED || $past(mode_o) == MODE_ACQUIRE));
endmodule

bind refmode_ctrl refmode_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_avail_i  (ref_avail_i),
  .hist_avail_i (hist_avail_i),
  .mode_o       (mode_o),
  .mode_oh_o    (mode_oh_o),
  .mode_chg_o   (mode_chg_o),
  .ref_chg_o    (ref_chg_o)
);

// File: tb/refmode_ctrl_tb.sv
module refmode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic ref_avail, lock, sync, hist, sw;
  logic [1:0] mode;
  logic [3:0] mode_oh;
  logic mchg, rchg;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;

  refmode_ctrl dut_i (
    .clk (clk), .rst_n (rst_n),
    .ref_avail_i (ref_avail), .freq_lock_i (lock), .sync_i (sync),
    .hist_avail_i (hist), .ref_switch_i (sw),
    .mode_o (mode), .mode_oh_o (mode_oh), .mode_chg_o (mchg), .ref_chg_o (rchg)
  );

  // vector: [8]ref [7]lock [6]sync [5]hist [4]sw | [3:2]mode [1]mode_chg [0]ref_chg
  localparam int NV = 20;
  localparam logic [8:0] VEC [NV] = '{
    9'b0_0_0_0_0_00_0_0, // R5 no ref stays free-running
    9'b1_0_0_0_0_01_1_0, // R2 ref -> acquiring
    9'b1_0_0_0_0_01_0_0, // R3 no lock yet
    9'b1_1_1_0_0_10_1_0, // R3 lock -> locked
    9'b1_0_1_0_0_10_0_0, // R8 sync alone holds locked
    9'b1_1_1_0_1_01_1_1, // R7 switch from locked
    9'b1_1_1_0_0_10_1_0, // R3 relock
    9'b0_1_1_1_0_11_1_0, // R4 loss beats lock, history -> holdover
    9'b0_0_0_1_0_11_0_0, // R4 stays in holdover
    9'b1_1_1_1_0_01_1_0, // R2 holdover -> acquiring despite lock
    9'b1_1_1_1_0_10_1_0, // R3
    9'b0_1_0_0_1_00_1_0, // R4 no history -> free-running, switch ignored
    9'b0_0_0_1_0_00_0_0, // R5 history does not enter holdover
    9'b1_0_0_0_1_01_1_0, // R10 switch ignored in free-running
    9'b1_1_1_0_1_01_0_1, // R7 switch beats lock in acquiring
    9'b1_1_0_0_0_10_1_0, // R3
    9'b1_0_0_0_0_01_1_0, // R8 loss of lock and sync
    9'b1_1_0_0_0_10_1_0, // R3
    9'b0_0_0_1_0_11_1_0, // R4 holdover
    9'b0_0_0_0_0_00_1_0  // R6 history lost -> free-running
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] c);
    {ref_avail, lock, sync, hist, sw} = c;
  endtask

  initial begin
    #(8ns * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(5'b1_1_1_1_1);
    repeat (3) @(negedge clk);
    chk("R1 reset mode", 32'(mode), 32'd0);
    chk("R1 reset strobes", 32'({mchg, rchg}), 32'd0);
    rst_n = 1'b1;
    drive(5'b0);
    repeat (4) @(negedge clk);
    chk("R1 after release", 32'({mode, mchg, rchg}), 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][8:4]);
      @(negedge clk);
      chk($sformatf("vec %0d mode (R2-R8)", i), 32'(mode), 32'(VEC[i][3:2]));
      chk($sformatf("vec %0d mode_chg R9", i), 32'(mchg), 32'(VEC[i][1]));
      chk($sformatf("vec %0d ref_chg R10", i), 32'(rchg), 32'(VEC[i][0]));
      chk($sformatf("vec %0d onehot R11", i), 32'(mode_oh), 32'(4'b1 << VEC[i][3:2]));
    end

    // R9: strobe lasts one cycle only
    drive(5'b1_0_0_0_0);
    @(negedge clk);
    chk("R9 enter acquiring", 32'({mode, mchg}), 32'b01_1);
    @(negedge clk);
    chk("R9 strobe drops", 32'(mchg), 32'd0);

    // R1: asynchronous reset mid-run
    #1ns rst_n = 1'b0;
    #1ns chk("R1 async reset", 32'({mode, mchg, rchg}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(5'b1_0_0_0_0);
    @(negedge clk);
    chk("R1 held during release sync", 32'(mode), 32'd0);
    repeat (3) @(negedge clk);
    chk("R2 acquire after release", 32'(mode), 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule